// File: doc/BRIEF.md
# Link Test Pattern Receiver Checker

This block sits behind the receive side of a wide parallel serial link and checks the built-in bring-up patterns that the far end transmits, one bit time per clock on every channel at once. It supports two tests. The walking test finds opens and shorts: one channel at a time carries a walking value for a fixed window while every other channel holds the opposite value. The random test compares every received bit against a local pseudo-random generator that runs in step with the transmitter.

Neither test has a start command of its own. Each one arms itself from the received data. The walking test starts on the first change on channel 0. The random test starts on the first rising bit on channel 0 that follows an all-zero preamble. Every mismatch is recorded per channel in a sticky failure vector and in an error flag. The walking test also raises a completion flag once the last channel has been checked. The random test runs until it is switched off and never reports completion.

Top module: `link_pattern_checker`

## Requirements
- R1: After reset, `fail_vec`, `err_flag` and `walk_done` are all zero.
- R2: Walking checking is enabled only while `chk_arm`, `walk_mode` and `bypass_en` are all 1. Random checking is enabled only while `chk_arm` and `rand_mode` are 1 and `walk_mode` is 0. With neither enabled, no comparison is made.
- R3: Once the walking test is enabled, the checker first waits until channel 0 shows the field value. It then waits for channel 0 to show the walking value, and the clock edge that samples it is edge t, the start of channel 0's window.
- R4: Channel k (k = 0..47) is sampled once, at edge t+8+16k. At that sample the expected value is the walking value on channel k and the field value on every other channel. A value that differs from expected only at some other bit time of the window causes no failure.
- R5: The walking value equals `walk_level`, and the field value is its inverse. With `walk_level`=0 the test therefore walks a zero across a field of ones.
- R6: `walk_done` rises on the edge that samples channel 47 and not before. It stays 1 while the walking test remains enabled, and it is 0 one cycle after the walking test is disabled.
- R7: Once the random test is enabled, the checker waits for one clock on which all channels are 0. The first later clock on which channel 0 is 1 is the first compared bit time.
- R8: The reference generator is a 12-bit register s, seeded with 0xFFF, whose expected bit is s[11] and whose next value is {s[10:0], s[10]^s[4]^s[2]}. From the first compared bit time onward, every channel is compared with the expected bit on every clock.
- R9: The random test never sets `walk_done`. It stops comparing as soon as `rand_mode` or `chk_arm` falls.
- R10: Each channel that mismatches at a compared bit time sets its bit of `fail_vec`, and `err_flag` is set with it. Both are visible one cycle later. Both are sticky while `chk_arm` stays 1 and are cleared while `chk_arm` is 0.
- R11: Data received while a test is enabled but not yet armed, or after it has stopped, leaves `fail_vec` and `err_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bits | input | 48 | Received bit of each channel |
| chk_arm | input | 1 | Receiver test enable; low clears results |
| rand_mode | input | 1 | Selects the pseudo-random test |
| walk_mode | input | 1 | Selects the walking shorts test |
| walk_level | input | 1 | Walking value for the shorts test |
| bypass_en | input | 1 | Receiver flushes data straight through; required for the shorts test |
| fail_vec | output | 48 | Sticky per-channel failure bits |
| err_flag | output | 1 | Sticky: any channel has failed |
| walk_done | output | 1 | Shorts test has checked all channels |

## Verification
The hardest thing to reach from the ports is the exact sampling instant inside each 16-bit window. A design that samples a few bit times early or late still passes an undisturbed pattern. The stimulus therefore removes the walking value from one channel at every bit time of its window except the centre, and from another channel only at the centre. Only the second channel may fail. Completion timing is pinned the same way: `walk_done` is checked one step before and one step after the data that lands on the last channel's centre. An injected bit error on the very first compared bit of the random stream confirms that the arming edge is itself checked.

// File: rtl/link_chk_pkg.sv
package link_chk_pkg;

  localparam int LFSR_W = 12;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

  typedef enum logic [2:0] {
    W_IDLE,
    W_SEEK,
    W_EDGE,
    W_RUN,
    W_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    R_IDLE,
    R_ZERO,
    R_EDGE,
    R_RUN
  } rand_state_e;

  // Taps for 1 + x^3 + x^5 + x^11, shifted toward the MSB output
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[10] ^ s[4] ^ s[2]};
  endfunction

endpackage

// File: rtl/lane_walk_tracker.sv
module lane_walk_tracker
  import link_chk_pkg::*;
#(
  parameter int NUM_LANES = 48,
  parameter int DWELL     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         walk_level,
  input  logic                         rx_lane0,
  output logic                         strobe,
  output logic [$clog2(NUM_LANES)-1:0] lane_idx,
  output logic                         done
);

  localparam int LANE_W = $clog2(NUM_LANES);
  localparam int CNT_W  = $clog2(DWELL);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);
  localparam logic [CNT_W-1:0]  HALF_LD   = CNT_W'(DWELL / 2 - 1);
  localparam logic [CNT_W-1:0]  FULL_LD   = CNT_W'(DWELL - 1);

  walk_state_e             state_q, state_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [LANE_W-1:0]       lane_q, lane_d;
  logic                    strobe_c;

  // next-state
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    lane_d   = lane_q;
    strobe_c = 1'b0;
    case (state_q)
      W_IDLE: if (enable) state_d = W_SEEK;
      W_SEEK: if (rx_lane0 == ~walk_level) state_d = W_EDGE;
      W_EDGE: begin
        if (rx_lane0 == walk_level) begin
          state_d = W_RUN;
          cnt_d   = HALF_LD;
          lane_d  = '0;
        end
      end
      W_RUN: begin
        if (cnt_q == '0) begin
          strobe_c = 1'b1;
          cnt_d    = FULL_LD;
          if (lane_q == LAST_LANE) state_d = W_DONE;
          else                     lane_d  = lane_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      W_DONE:  state_d = W_DONE;
      default: state_d = W_IDLE;
    endcase
    if (!enable) state_d = W_IDLE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      cnt_q   <= '0;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lane_q  <= lane_d;
    end
  end

  assign strobe   = strobe_c & enable;
  assign lane_idx = lane_q;
  assign done     = (state_q == W_DONE);

  // R4: lane pointer never runs past the last channel
  a_r4_lane_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lane_q <= LAST_LANE);

  // R6: completion holds while the test stays enabled
  a_r6_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_DONE && enable) |=> (state_q == W_DONE));

  // R3: run state is only entered from the edge wait
  a_r3_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_RUN) |-> ($past(state_q) == W_RUN || $past(state_q) == W_EDGE));

endmodule

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import link_chk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rx_all_zero,
  input  logic rx_lane0,
  output logic cmp_valid,
  output logic exp_bit
);

  rand_state_e       state_q, state_d;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              cmp_c, exp_c;

  // next-state
  always_comb begin
    state_d = state_q;
    lfsr_d  = lfsr_q;
    cmp_c   = 1'b0;
    exp_c   = 1'b0;
    case (state_q)
      R_IDLE: begin
        lfsr_d = LFSR_SEED;
        if (enable) state_d = R_ZERO;
      end
      R_ZERO: if (rx_all_zero) state_d = R_EDGE;
      R_EDGE: begin
        if (rx_lane0) begin
          cmp_c   = 1'b1;
          exp_c   = LFSR_SEED[LFSR_W-1];
          lfsr_d  = lfsr_next(LFSR_SEED);
          state_d = R_RUN;
        end
      end
      R_RUN: begin
        cmp_c  = 1'b1;
        exp_c  = lfsr_q[LFSR_W-1];
        lfsr_d = lfsr_next(lfsr_q);
      end
      default: state_d = R_IDLE;
    endcase
    if (!enable) state_d = R_IDLE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= R_IDLE;
      lfsr_q  <= LFSR_SEED;
    end else begin
      state_q <= state_d;
      lfsr_q  <= lfsr_d;
    end
  end

  assign cmp_valid = cmp_c & enable;
  assign exp_bit   = exp_c;

  // R8: generator never locks up in the all-zero state
  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R7: streaming only follows the arming edge
  a_r7_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == R_RUN) |-> ($past(state_q) == R_RUN || $past(state_q) == R_EDGE));

endmodule

// File: rtl/fail_accum.sv
module fail_accum #(
  parameter int NUM_LANES = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 cmp_valid,
  input  logic [NUM_LANES-1:0] rx_bits,
  input  logic [NUM_LANES-1:0] exp_bits,
  output logic [NUM_LANES-1:0] fail_vec,
  output logic                 err_flag
);

  logic [NUM_LANES-1:0] fail_q, fail_d, miss;
  logic                 err_q, err_d;
  logic                 upd_en;

  assign miss   = rx_bits ^ exp_bits;
  assign upd_en = clear | cmp_valid;

  // next-state
  always_comb begin
    if (clear) begin
      fail_d = '0;
      err_d  = 1'b0;
    end else begin
      fail_d = fail_q | miss;
      err_d  = err_q | (|miss);
    end
  end

  // registers, written only when a compare or clear occurs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= '0;
      err_q  <= 1'b0;
    end else if (upd_en) begin
      fail_q <= fail_d;
      err_q  <= err_d;
    end
  end

  assign fail_vec = fail_q;
  assign err_flag = err_q;

  // R10: recorded failures are never lost while armed
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((fail_vec & $past(fail_vec)) == $past(fail_vec)));

  // R10: disarming wipes the results
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fail_vec == '0 && !err_flag));

  // R10: the error flag tracks the failure vector
  a_r10_err_any: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag == (|fail_vec));

endmodule

// File: rtl/link_pattern_checker.sv
module link_pattern_checker #(
  parameter int NUM_LANES = 48,
  parameter int DWELL     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] rx_bits,
  input  logic                 chk_arm,
  input  logic                 rand_mode,
  input  logic                 walk_mode,
  input  logic                 walk_level,
  input  logic                 bypass_en,
  output logic [NUM_LANES-1:0] fail_vec,
  output logic                 err_flag,
  output logic                 walk_done
);

  localparam int LANE_W = $clog2(NUM_LANES);

  logic                 rst_meta, rst_n_s;
  logic                 walk_on, rand_on;
  logic                 walk_strobe, rnd_valid, rnd_bit;
  logic [LANE_W-1:0]    lane_idx;
  logic [NUM_LANES-1:0] lane_hot, exp_bits;
  logic                 any_valid;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign walk_on = chk_arm & walk_mode & bypass_en;
  assign rand_on = chk_arm & rand_mode & ~walk_mode;

  lane_walk_tracker #(.NUM_LANES(NUM_LANES), .DWELL(DWELL)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .enable     (walk_on),
    .walk_level (walk_level),
    .rx_lane0   (rx_bits[0]),
    .strobe     (walk_strobe),
    .lane_idx   (lane_idx),
    .done       (walk_done)
  );

  prbs_ref_gen u_prbs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .enable      (rand_on),
    .rx_all_zero (rx_bits == '0),
    .rx_lane0    (rx_bits[0]),
    .cmp_valid   (rnd_valid),
    .exp_bit     (rnd_bit)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_hot
    assign lane_hot[i] = (lane_idx == LANE_W'(i));
  end

  always_comb begin
    if (walk_strobe) exp_bits = walk_level ? lane_hot : ~lane_hot;
    else             exp_bits = {NUM_LANES{rnd_bit}};
  end

  assign any_valid = walk_strobe | rnd_valid;

  fail_accum #(.NUM_LANES(NUM_LANES)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clear     (~chk_arm),
    .cmp_valid (any_valid),
    .rx_bits   (rx_bits),
    .exp_bits  (exp_bits),
    .fail_vec  (fail_vec),
    .err_flag  (err_flag)
  );

  // R2: the two checkers never compare on the same clock
  a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(walk_strobe && rnd_valid));

  // R9: completion cannot survive without the walking mode
  a_r9_no_done_rand: assert property (@(posedge clk) disable iff (!rst_n_s)
    !walk_mode |=> !walk_done);

  // R6: completion only follows a cycle with the walking test enabled
  a_r6_done_needs_mode: assert property (@(posedge clk) disable iff (!rst_n_s)
    walk_done |-> $past(walk_on));

endmodule

// File: tb/sim_link_pattern_checker.sv
module sim_link_pattern_checker;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] rx;
  logic          arm, rnd_en, walk_en, lvl, byp;
  logic [NL-1:0] fail_vec;
  logic          err_flag, walk_done;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    logic [NL-1:0] fv;
    logic        err;
    logic        done;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_pattern_checker u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_bits    (rx),
    .chk_arm    (arm),
    .rand_mode  (rnd_en),
    .walk_mode  (walk_en),
    .walk_level (lvl),
    .bypass_en  (byp),
    .fail_vec   (fail_vec),
    .err_flag   (err_flag),
    .walk_done  (walk_done)
  );

  // monitor: pops scoreboard items whose cycle has come
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_tests++;
      if (e.due != cyc || fail_vec !== e.fv || err_flag !== e.err || walk_done !== e.done) begin
        n_fail++;
        $display("FAIL %s: got fv=%h err=%b done=%b, expected fv=%h err=%b done=%b",
                 e.tag, fail_vec, err_flag, walk_done, e.fv, e.err, e.done);
      end
    end
  end

  function automatic logic [11:0] ref_next(input logic [11:0] s);
    return {s[10:0], s[10] ^ s[4] ^ s[2]};
  endfunction

  function automatic logic [NL-1:0] bit_at(input int n);
    logic [NL-1:0] v;
    v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  task automatic expect_out(input logic [NL-1:0] fv, input logic e, input logic d, input string tag);
    exp_t it;
    it.due = cyc + 1; it.fv = fv; it.err = e; it.done = d; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(input logic [NL-1:0] d);
    @(posedge clk); #1;
    rx = d;
  endtask

  task automatic set_modes(input logic a, input logic r, input logic w, input logic l, input logic b);
    @(posedge clk); #1;
    arm = a; rnd_en = r; walk_en = w; lvl = l; byp = b;
  endtask

  // walking transmitter with optional faults; checks completion around the last sample
  task automatic walk_tx(input logic level, input int short_lane, input int short_win,
                         input int open_lane, input int glitch_lane, input int ctr_lane,
                         input logic [NL-1:0] exp_fv, input logic exp_done);
    for (int k = 0; k < NL; k++) begin
      for (int off = 0; off < 16; off++) begin
        logic [NL-1:0] d;
        d = level ? '0 : '1;
        if (!(k == open_lane) && !(k == glitch_lane && off != 8) && !(k == ctr_lane && off == 8))
          d[k] = level;
        if (k == short_win) d[short_lane] = level;
        step(d);
        if (k == NL-1 && off == 7)
          expect_out(exp_fv, |exp_fv, 1'b0, "R6 no completion before last centre sample");
        if (k == NL-1 && off == 8)
          expect_out(exp_fv, |exp_fv, exp_done, "R4 R5 R6 result at last centre sample");
      end
    end
  endtask

  task automatic rand_tx(input int n, input int ia, input int la, input int ib, input int lb);
    logic [11:0] s;
    s = 12'hFFF;
    for (int i = 0; i < n; i++) begin
      logic [NL-1:0] d;
      d = {NL{s[11]}};
      if (i == ia) d[la] = ~d[la];
      if (i == ib) d[lb] = ~d[lb];
      step(d);
      s = ref_next(s);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout, expected end of run");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] fv;
    rst_n = 1'b0;
    rx = '0; arm = 0; rnd_en = 0; walk_en = 0; lvl = 0; byp = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step('0);
    expect_out('0, 1'b0, 1'b0, "R1 reset state");

    // clean walking-one test, glitches off-centre on lane 2 (R3 R4)
    set_modes(1, 0, 1, 1, 1);
    repeat (4) step('0);
    walk_tx(1'b1, -1, -1, -1, 2, -1, '0, 1'b1);
    repeat (2) step('0);
    expect_out('0, 1'b0, 1'b1, "R6 completion holds, R3 armed on channel 0");
    set_modes(1, 0, 0, 1, 1);
    expect_out('0, 1'b0, 1'b0, "R6 completion clears with mode");

    // walking-zero test with short, open and centre drop
    set_modes(0, 0, 0, 0, 1);
    set_modes(1, 0, 1, 0, 1);
    repeat (4) step('1);
    fv = bit_at(5) | bit_at(20) | bit_at(30);
    walk_tx(1'b0, 5, 9, 20, -1, 30, fv, 1'b1);
    repeat (2) step('1);
    expect_out(fv, 1'b1, 1'b1, "R5 R4 short/open/centre faults");
    set_modes(1, 0, 0, 0, 1);
    expect_out(fv, 1'b1, 1'b0, "R10 sticky after mode drop");
    set_modes(0, 0, 0, 0, 1);
    expect_out('0, 1'b0, 1'b0, "R10 cleared by disarm");

    // no bypass: shorts test must not run
    set_modes(1, 0, 1, 1, 0);
    repeat (4) step('0);
    walk_tx(1'b1, -1, -1, 7, -1, -1, '0, 1'b0);
    expect_out('0, 1'b0, 1'b0, "R2 shorts test needs bypass");

    // random test, junk before preamble
    set_modes(0, 0, 0, 0, 0);
    set_modes(1, 1, 0, 0, 0);
    repeat (6) step({16'hA5C3, 16'h0F0F, 16'h7E81});
    expect_out('0, 1'b0, 1'b0, "R11 data before preamble ignored");
    repeat (4) step('0);
    rand_tx(200, -1, 0, -1, 0);
    expect_out('0, 1'b0, 1'b0, "R7 R8 R9 clean random stream, no completion");

    // random test with injected errors
    set_modes(0, 0, 0, 0, 0);
    set_modes(1, 1, 0, 0, 0);
    repeat (4) step('0);
    fv = bit_at(40) | bit_at(17);
    rand_tx(120, 0, 40, 50, 17);
    expect_out(fv, 1'b1, 1'b0, "R8 R7 errors incl. first compared bit");
    set_modes(1, 0, 0, 0, 0);
    repeat (5) step({24'h123456, 24'hFEDCBA});
    expect_out(fv, 1'b1, 1'b0, "R9 R11 stopped after rand mode drop");

    // random mode blocked while walking mode set
    set_modes(1, 1, 1, 0, 0);
    repeat (4) step('0);
    rand_tx(60, 10, 3, -1, 0);
    expect_out(fv, 1'b1, 1'b0, "R2 random test blocked by walking mode");

    repeat (3) step('0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule